// File: doc/BRIEF.md
# Two-Wire Bus Serial Clock Divider

This block derives the serial clock of a two-wire bus master from a fast system clock. It does not use one wide modulo counter. The bus rate comes from four chained counters: a power-of-two prescaler, an (M+1) stage, a fixed half-period stage of THP+1 counts, and a ten-step stage. Two ten-step passes, one for the low half and one for the high half, give the fixed factor of twenty per bus period. The bus engine programs M and N through one packed control byte. It receives a one-cycle tick at every phase change, a request to pull SCL low, and a two-bit phase indicator that also marks the midpoint of each half.

The block never stretches the clock itself. While it has released SCL and a slave still holds the line low, every stage freezes until the line reads high again. Divider settings are captured only when a phase ends, so a write in the middle of a phase never shortens or lengthens the half-period already running.

Top module: `i2c_clkdiv`

## Requirements
- R1: One SCL half-period lasts exactly 10 × (M+1) × (THP+1) × 2^N system clock cycles, so a full bus period is 20 × (M+1) × (THP+1) × 2^N cycles.
- R2: The control byte carries M (0 to 15) in bits 6:3 and N (0 to 7) in bits 2:0. Bit 7 has no effect on the timing.
- R3: The control byte is sampled only in the last cycle of a phase. A change at any other time leaves the running half-period unchanged and takes effect from the next one.
- R4: While reset is asserted, scl_low is 0, tick is 0 and phase is 2'b10. After release, the first half is a high phase timed with M=0 and N=0, whatever the control byte holds.
- R5: tick is a single-cycle pulse in the first cycle of each new phase. scl_low changes value only in cycles where tick is 1, and it alternates at every tick.
- R6: phase[1] is 1 in the high (released) half and 0 in the low half. phase[0] is 0 in the first five tenths of a half and 1 in the last five, so it rises exactly half a half-period after the tick.
- R7: While scl_low is 0 and scl_in reads 0, all counters hold. The high half is lengthened by exactly the number of such cycles, and no tick occurs during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 8 | Packed divider settings: M in bits 6:3, N in bits 2:0 |
| scl_in | input | 1 | Sampled level of the SCL line (synchronous to clk) |
| tick | output | 1 | One-cycle pulse at the start of each phase |
| scl_low | output | 1 | 1 requests SCL to be driven low, 0 releases it |
| phase | output | 2 | {high half, second half of the current phase} |

## Verification
The hardest case to reach is a slave holding SCL low while the divider is partway through its high half. The bench models the wire as the AND of the divider's release and a slave hold. It raises the hold in the first cycle of a high phase for a known number of cycles and expects the half to grow by exactly that amount. Settings changes in mid-phase are reached by writing a new control byte a few cycles after a tick and timing two phases in a row. The widest settings are covered by a vector table whose half-period lengths run from 20 to over 20,000 cycles.

// File: rtl/i2c_clkdiv.sv
module i2c_clkdiv #(
  parameter int THP = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctrl,
  input  logic       scl_in,
  output logic       tick,
  output logic       scl_low,
  output logic [1:0] phase
);
  localparam int TW = (THP > 0) ? $clog2(THP + 1) : 1;
  localparam logic [TW-1:0] THP_LAST = TW'(THP);

  logic [6:0]    pre_cnt;
  logic [3:0]    m_cnt;
  logic [TW-1:0] thp_cnt;
  logic [3:0]    ten_cnt;
  logic [3:0]    m_q;
  logic [2:0]    n_q;

  logic [7:0] pre_span;
  logic run, pre_last, m_last, thp_last, ten_last;
  logic step_m, step_t, step_u, last;

  assign pre_span = 8'd1 << n_q;
  assign run      = scl_low | scl_in;
  assign pre_last = pre_cnt == (pre_span[6:0] - 7'd1);
  assign m_last   = m_cnt == m_q;
  assign thp_last = thp_cnt == THP_LAST;
  assign ten_last = ten_cnt == 4'd9;

  assign step_m = run & pre_last;
  assign step_t = step_m & m_last;
  assign step_u = step_t & thp_last;
  assign last   = step_u & ten_last;

  assign phase = {~scl_low, ten_cnt >= 4'd5};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      m_cnt   <= '0;
      thp_cnt <= '0;
      ten_cnt <= '0;
      m_q     <= '0;
      n_q     <= '0;
      scl_low <= 1'b0;
      tick    <= 1'b0;
    end else begin
      tick <= last;
      if (run)    pre_cnt <= pre_last ? '0 : pre_cnt + 7'd1;
      if (step_m) m_cnt   <= m_last   ? '0 : m_cnt + 4'd1;
      if (step_t) thp_cnt <= thp_last ? '0 : thp_cnt + TW'(1);
      if (step_u) ten_cnt <= ten_last ? '0 : ten_cnt + 4'd1;
      if (last) begin
        scl_low <= ~scl_low;
        m_q     <= ctrl[6:3];
        n_q     <= ctrl[2:0];
      end
    end
  end
endmodule

// File: rtl/i2c_clkdiv_chk.sv
module i2c_clkdiv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       tick,
  input logic       scl_low,
  input logic [1:0] phase,
  input logic [3:0] m_q,
  input logic [2:0] n_q
);
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_toggle_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low != $past(scl_low)) |-> tick);

  assert_cfg_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({m_q, n_q} != $past({m_q, n_q})) |-> tick);

  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !scl_in) |=> (!tick && !scl_low && $stable(phase)));
endmodule

bind i2c_clkdiv i2c_clkdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .tick(tick),
  .scl_low(scl_low), .phase(phase), .m_q(m_q), .n_q(n_q)
);

// File: tb/i2c_clkdiv_bench.sv
module i2c_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h18;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       tick, scl_low;
  logic [1:0] phase;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign scl_in = !scl_low && !stretch;

  i2c_clkdiv #(.THP(1)) u_i2c_clkdiv (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .scl_in(scl_in),
    .tick(tick), .scl_low(scl_low), .phase(phase)
  );

  // {ctrl, expected half-period} with THP=1: 20*(M+1)*2^N
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 24'd20},   {8'h18, 24'd80},   {8'h02, 24'd80},
    {8'h11, 24'd120},  {8'h78, 24'd320},  {8'h0B, 24'd320},
    {8'h80, 24'd20},   {8'h07, 24'd2560}, {8'h2C, 24'd1920},
    {8'h7E, 24'd20480}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic measure(output int h, output int half_at);
    h = 0;
    half_at = -1;
    do begin
      @(negedge clk);
      h++;
      if (half_at < 0 && phase[0]) half_at = h;
    end while (!tick);
  endtask

  initial begin
    int h, ha, exp;
    bit pre;
    // R4: reset state
    #3;
    check(scl_low == 1'b0, "R4 scl_low in reset", scl_low, 0);
    check(tick == 1'b0, "R4 tick in reset", tick, 0);
    check(phase == 2'b10, "R4 phase in reset", phase, 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    measure(h, ha);
    check(h == 20, "R4 first half uses M=0 N=0", h, 20);
    check(scl_low == 1'b1, "R4 R5 first tick enters low", scl_low, 1);

    // R1 R2 R6 R5: vector table
    for (int i = 0; i < NV; i++) begin
      ctrl = VEC[i][31:24];
      exp = int'(VEC[i][23:0]);
      wait_tick();
      check(phase[0] == 1'b0, "R6 first half at tick", phase[0], 0);
      pre = scl_low;
      measure(h, ha);
      check(h == exp, "R1 R2 half-period", h, exp);
      check(ha == exp / 2, "R6 midpoint", ha, exp / 2);
      check(scl_low != pre, "R5 toggle at tick", scl_low, !pre);
    end

    // R3: mid-phase change waits for the boundary
    ctrl = 8'h00;
    wait_tick();
    repeat (3) @(negedge clk);
    ctrl = 8'h18;
    measure(h, ha);
    h = h + 3;
    check(h == 20, "R3 running phase unchanged", h, 20);
    measure(h, ha);
    check(h == 80, "R3 new setting next phase", h, 80);

    // R7: slave holds SCL low in the high half
    ctrl = 8'h00;
    do wait_tick(); while (scl_low);
    h = 0;
    stretch = 1'b1;
    do begin
      @(negedge clk);
      h++;
      if (h == 7) stretch = 1'b0;
      if (h <= 7 && (scl_low || phase != 2'b10 || tick)) begin
        check(1'b0, "R7 frozen during hold", {30'd0, phase}, 2);
      end
    end while (!tick);
    check(h == 27, "R7 stretched high half", h, 27);
    check(scl_low == 1'b1, "R7 enters low after stretch", scl_low, 1);
    measure(h, ha);
    check(h == 20, "R7 low half unaffected", h, 20);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule